// File: doc/BRIEF.md
# Page Translation Lookaside Cache

This block is a small, fully associative store of recent page translations for a memory management unit. Pages are 256 bytes. A lookup presents a logical address and a privilege flag. In the same cycle the block returns a hit flag and the physical address. That address is the stored physical page with the untranslated low byte of the logical address appended. The privilege flag sets a 3-bit address-space code that is kept with every entry. The code is 5 for supervisor accesses and 1 for user accesses, so one logical page can hold two independent translations.

An insert port loads a new translation after a miss has been resolved elsewhere. An insert is ignored when the same page and code are already cached. Otherwise it fills the lowest-numbered empty slot. When every slot is taken, it overwrites the slot chosen by a round-robin pointer. The whole store is cleared in one cycle by reset, by an explicit flush command, or by certain control-register writes.

A fill controller tracks occupancy with three states. In ST_EMPTY no entry is valid. In ST_PARTIAL some slots are free. In ST_FULL every slot is valid, and victims come from the round-robin pointer. The transitions are:
- ST_EMPTY to ST_PARTIAL on the first accepted insert.
- ST_PARTIAL to ST_FULL when an accepted insert takes the last free slot.
- ST_FULL holds on accepted inserts.
- Any state goes to ST_EMPTY on a flush.

Top module: `xlat_cache`

## Requirements
- R1: After reset every entry is invalid. Every lookup misses, and a miss drives lk_paddr to zero.
- R2: A lookup hits only when a valid entry holds the same logical page (address bits 31:8) and the same space code. lk_paddr is then the stored physical page in bits 31:8 and lk_laddr bits 7:0 in the low byte.
- R3: The space code is 5 when the supervisor flag is 1 and 1 when it is 0. A translation inserted under one privilege misses under the other, and the two privileges can hold different translations for the same page.
- R4: An insert whose page and space code match a valid entry changes nothing. A later lookup returns the physical page that was stored first.
- R5: While any entry is invalid, an accepted insert is written to the lowest-index invalid entry.
- R6: When all entries are valid, an insert goes to the entry named by the round-robin pointer. The pointer then advances by one and wraps from ENTRIES-1 to 0.
- R7: A flush_cmd pulse invalidates every entry and sets the pointer to 0. A flush in the same cycle as an insert wins, and the insert is dropped.
- R8: A control write flushes the store in the way R7 describes only when all of these hold:
  - command bits 15:13 are 010;
  - command bits 12:10 select register 0, 2 or 3;
  - direction bit 9 is 0;
  - flush-disable bit 8 is 0.
  Any other command word leaves the contents intact.
- R9: A lookup in the same cycle as an insert of that page misses. The new translation hits from the next cycle on.
- R10: After a flush, filling and then overflowing the store starts replacement again at entry 0, which holds the first page inserted after the flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, clears the store |
| lk_sup | input | 1 | Privilege of the lookup, 1 = supervisor |
| lk_laddr | input | 32 | Logical address to translate |
| lk_hit | output | 1 | Lookup found a matching entry |
| lk_paddr | output | 32 | Translated address, zero on a miss |
| ins_en | input | 1 | Insert request |
| ins_sup | input | 1 | Privilege of the inserted translation |
| ins_lpage | input | 24 | Logical page (address bits 31:8) to insert |
| ins_ppage | input | 24 | Physical page (address bits 31:8) to insert |
| flush_cmd | input | 1 | Invalidate everything |
| ctl_wr | input | 1 | Control-register write strobe |
| ctl_cmd | input | 8 | Command word bits 15:8: group, register select, direction, flush-disable |

## Verification
The bench keeps its own model of the slot array and predicts every lookup from it. Single translations under both privileges show whether the space code takes part in the match. Repeated inserts with a different physical page separate a true duplicate check from a plain overwrite. Overflowing the store by 8 and then by 15 further pages makes the sequence of evicted pages visible: lowest-free filling, pointer advance and wrap. This is repeated after a flush to confirm that the pointer restarts. A set of control command words, differing in one field at a time, shows which fields decide whether a write flushes. Paired lookup and insert of one page in the same cycle shows the one-cycle visibility rule.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    localparam int FC_W = 3;

    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_PARTIAL = 2'd1,
        ST_FULL    = 2'd2
    } fill_state_e;

    // space code: supervisor -> 5, user -> 1
    function automatic logic [FC_W-1:0] space_code(input logic sup);
        return {sup, 1'b0, 1'b1};
    endfunction

    // command bits 15:8 of a control write; flush when group 010,
    // register 0/2/3, direction 0 (write) and flush-disable 0
    function automatic logic ctl_flushes(input logic [15:8] cmd);
        logic grp_ok;
        logic reg_ok;
        grp_ok = (cmd[15:13] == 3'b010);
        reg_ok = (cmd[12:10] == 3'd0) || (cmd[12:10] == 3'd2) || (cmd[12:10] == 3'd3);
        return grp_ok && reg_ok && !cmd[9] && !cmd[8];
    endfunction

endpackage

// File: rtl/xlat_entry.sv
module xlat_entry #(
    parameter int PAGE_W = 24,
    parameter int FC_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [PAGE_W-1:0] in_lpage,
    input  logic [FC_W-1:0]   in_fc,
    input  logic [PAGE_W-1:0] in_ppage,
    input  logic [PAGE_W-1:0] lk_lpage,
    input  logic [FC_W-1:0]   lk_fc,
    output logic              valid,
    output logic              lk_match,
    output logic              in_match,
    output logic [PAGE_W-1:0] ppage
);

    logic              vld_q;
    logic [PAGE_W-1:0] lpage_q;
    logic [FC_W-1:0]   fc_q;
    logic [PAGE_W-1:0] ppage_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q   <= 1'b0;
            lpage_q <= '0;
            fc_q    <= '0;
            ppage_q <= '0;
        end else if (clr) begin
            vld_q   <= 1'b0;
            lpage_q <= '0;
            fc_q    <= '0;
        end else if (wr_en) begin
            vld_q   <= 1'b1;
            lpage_q <= in_lpage;
            fc_q    <= in_fc;
            ppage_q <= in_ppage;
        end
    end

    assign valid    = vld_q;
    assign lk_match = vld_q && (lpage_q == lk_lpage) && (fc_q == lk_fc);
    assign in_match = vld_q && (lpage_q == in_lpage) && (fc_q == in_fc);
    assign ppage    = ppage_q;

endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
    parameter int ENTRIES = 22,
    parameter int IDX_W   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               adv,
    input  logic               use_rr,
    input  logic [ENTRIES-1:0] valid_vec,
    output logic [IDX_W-1:0]   victim,
    output logic [IDX_W-1:0]   rr_ptr
);

    logic [IDX_W-1:0] rr_q;
    logic [IDX_W-1:0] free_idx;

    // lowest-index free slot: scan from the top so the lowest wins
    always_comb begin
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_vec[i]) free_idx = IDX_W'(i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else if (clr) begin
            rr_q <= '0;
        end else if (adv && use_rr) begin
            rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
        end
    end

    assign victim = use_rr ? rr_q : free_idx;
    assign rr_ptr = rr_q;

endmodule

// File: rtl/xlat_fill_ctrl.sv
module xlat_fill_ctrl
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 22,
    parameter int CNT_W   = 5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        take,
    output fill_state_e state,
    output logic        use_rr
);

    fill_state_e state_q;
    fill_state_e state_d;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (take && (state_q != ST_FULL)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        if (clr) begin
            state_d = ST_EMPTY;
        end else begin
            unique case (state_q)
                ST_EMPTY: begin
                    if (take) state_d = (ENTRIES == 1) ? ST_FULL : ST_PARTIAL;
                end
                ST_PARTIAL: begin
                    if (take && (cnt_q == CNT_W'(ENTRIES - 1))) state_d = ST_FULL;
                end
                ST_FULL: begin
                    state_d = ST_FULL;
                end
                default: state_d = ST_EMPTY;
            endcase
        end
    end

    always_comb begin
        use_rr = (state_q == ST_FULL);
    end

    assign state = state_q;

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
    import xlat_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int PAGE_SHIFT = 8,
    parameter int ENTRIES    = 22
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         lk_sup,
    input  logic [ADDR_W-1:0]            lk_laddr,
    output logic                         lk_hit,
    output logic [ADDR_W-1:0]            lk_paddr,
    input  logic                         ins_en,
    input  logic                         ins_sup,
    input  logic [ADDR_W-1:PAGE_SHIFT]   ins_lpage,
    input  logic [ADDR_W-1:PAGE_SHIFT]   ins_ppage,
    input  logic                         flush_cmd,
    input  logic                         ctl_wr,
    input  logic [15:8]                  ctl_cmd
);

    localparam int PAGE_W = ADDR_W - PAGE_SHIFT;
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam int CNT_W  = $clog2(ENTRIES + 1);

    logic [PAGE_W-1:0]  lk_lpage;
    logic [FC_W-1:0]    lk_fc;
    logic [FC_W-1:0]    in_fc;
    logic [ENTRIES-1:0] valid_vec;
    logic [ENTRIES-1:0] lk_match_vec;
    logic [ENTRIES-1:0] in_match_vec;
    logic [PAGE_W-1:0]  pp_arr [ENTRIES];
    logic [PAGE_W-1:0]  hit_ppage;
    logic [IDX_W-1:0]   victim;
    logic [IDX_W-1:0]   rr_ptr;
    logic               dup;
    logic               flush_now;
    logic               take;
    logic               use_rr;
    fill_state_e        state_q;

    assign lk_lpage  = lk_laddr[ADDR_W-1:PAGE_SHIFT];
    assign lk_fc     = space_code(lk_sup);
    assign in_fc     = space_code(ins_sup);
    assign dup       = |in_match_vec;
    assign flush_now = flush_cmd || (ctl_wr && ctl_flushes(ctl_cmd));
    assign take      = ins_en && !dup && !flush_now;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
        xlat_entry #(
            .PAGE_W (PAGE_W),
            .FC_W   (FC_W)
        ) u_entry (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (flush_now),
            .wr_en    (take && (victim == IDX_W'(i))),
            .in_lpage (ins_lpage),
            .in_fc    (in_fc),
            .in_ppage (ins_ppage),
            .lk_lpage (lk_lpage),
            .lk_fc    (lk_fc),
            .valid    (valid_vec[i]),
            .lk_match (lk_match_vec[i]),
            .in_match (in_match_vec[i]),
            .ppage    (pp_arr[i])
        );
    end

    xlat_victim #(
        .ENTRIES (ENTRIES),
        .IDX_W   (IDX_W)
    ) u_victim (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (flush_now),
        .adv       (take),
        .use_rr    (use_rr),
        .valid_vec (valid_vec),
        .victim    (victim),
        .rr_ptr    (rr_ptr)
    );

    xlat_fill_ctrl #(
        .ENTRIES (ENTRIES),
        .CNT_W   (CNT_W)
    ) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (flush_now),
        .take   (take),
        .state  (state_q),
        .use_rr (use_rr)
    );

    // at most one slot matches, so an AND-OR mux selects its page
    always_comb begin
        hit_ppage = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            hit_ppage = hit_ppage | ({PAGE_W{lk_match_vec[i]}} & pp_arr[i]);
        end
    end

    assign lk_hit   = |lk_match_vec;
    assign lk_paddr = lk_hit ? {hit_ppage, lk_laddr[PAGE_SHIFT-1:0]} : '0;

endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 22,
    parameter int IDX_W   = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               flush_now,
    input logic               take,
    input logic               dup,
    input logic               ins_en,
    input logic [ENTRIES-1:0] valid_vec,
    input logic [ENTRIES-1:0] lk_match_vec,
    input logic [IDX_W-1:0]   rr_ptr,
    input fill_state_e        state_q
);

    assert_flush_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush_now |=> (valid_vec == '0) && (rr_ptr == '0));

    assert_single_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match_vec));

    assert_dup_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_en && dup && !flush_now) |=> (valid_vec == $past(valid_vec)) && $stable(rr_ptr));

    assert_fill_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (take && (state_q != ST_FULL)) |=>
            ($countones(valid_vec) == $countones($past(valid_vec)) + 1) && $stable(rr_ptr));

    assert_rr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (take && (state_q == ST_FULL)) |=>
            (rr_ptr == (($past(rr_ptr) == IDX_W'(ENTRIES - 1)) ? '0 : $past(rr_ptr) + 1'b1)));

    assert_full_state_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FULL) == (&valid_vec));

    assert_rr_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rr_ptr < IDX_W'(ENTRIES));

endmodule

bind xlat_cache xlat_cache_chk #(
    .ENTRIES (ENTRIES),
    .IDX_W   (IDX_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush_now    (flush_now),
    .take         (take),
    .dup          (dup),
    .ins_en       (ins_en),
    .valid_vec    (valid_vec),
    .lk_match_vec (lk_match_vec),
    .rr_ptr       (rr_ptr),
    .state_q      (state_q)
);

// File: tb/sim_xlat_cache.sv
`timescale 1ns/1ps
module sim_xlat_cache;

    localparam int N = 22;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_sup = 1'b0;
    logic [31:0] lk_laddr = '0;
    logic        lk_hit;
    logic [31:0] lk_paddr;
    logic        ins_en = 1'b0;
    logic        ins_sup = 1'b0;
    logic [31:8] ins_lpage = '0;
    logic [31:8] ins_ppage = '0;
    logic        flush_cmd = 1'b0;
    logic        ctl_wr = 1'b0;
    logic [15:8] ctl_cmd = '0;

    always #10 clk = ~clk;

    xlat_cache u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_sup    (lk_sup),
        .lk_laddr  (lk_laddr),
        .lk_hit    (lk_hit),
        .lk_paddr  (lk_paddr),
        .ins_en    (ins_en),
        .ins_sup   (ins_sup),
        .ins_lpage (ins_lpage),
        .ins_ppage (ins_ppage),
        .flush_cmd (flush_cmd),
        .ctl_wr    (ctl_wr),
        .ctl_cmd   (ctl_cmd)
    );

    typedef struct {
        logic        hit;
        logic [31:0] pa;
        string       req;
    } exp_t;

    exp_t q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 0;

    // behavioural model of the slot array
    logic [23:0] m_lp [N];
    logic [2:0]  m_fc [N];
    logic [23:0] m_pp [N];
    logic        m_v  [N];
    int          m_rr;

    function automatic logic [2:0] code_of(input logic s);
        return s ? 3'd5 : 3'd1;
    endfunction

    function automatic logic cmd_flush(input logic [15:8] c);
        return (c[15:13] == 3'b010) && (c[12:10] == 3'd0 || c[12:10] == 3'd2 || c[12:10] == 3'd3)
               && !c[9] && !c[8];
    endfunction

    task automatic model_clear();
        for (int i = 0; i < N; i++) begin
            m_v[i] = 1'b0; m_lp[i] = '0; m_fc[i] = '0;
        end
        m_rr = 0;
    endtask

    // one cycle: drive, predict, push, then advance the model past the edge
    task automatic op(input bit lk, input logic [31:0] la, input logic ls,
                      input bit ins, input logic [23:0] ilp, input logic [23:0] ipp, input logic is,
                      input bit fl, input bit cw, input logic [15:8] cc, input string req);
        exp_t e;
        bit   is_dup;
        int   slot;
        @(posedge clk);
        #2;
        lk_sup = ls; lk_laddr = la;
        ins_en = ins; ins_lpage = ilp; ins_ppage = ipp; ins_sup = is;
        flush_cmd = fl; ctl_wr = cw; ctl_cmd = cc;
        if (lk) begin
            e.hit = 1'b0; e.pa = '0; e.req = req;
            for (int i = 0; i < N; i++) begin
                if (m_v[i] && m_lp[i] == la[31:8] && m_fc[i] == code_of(ls)) begin
                    e.hit = 1'b1; e.pa = {m_pp[i], la[7:0]};
                end
            end
            q.push_back(e);
        end
        if (fl || (cw && cmd_flush(cc))) begin
            model_clear();
        end else if (ins) begin
            is_dup = 0;
            for (int i = 0; i < N; i++)
                if (m_v[i] && m_lp[i] == ilp && m_fc[i] == code_of(is)) is_dup = 1;
            if (!is_dup) begin
                slot = -1;
                for (int i = N - 1; i >= 0; i--) if (!m_v[i]) slot = i;
                if (slot < 0) begin
                    slot = m_rr;
                    m_rr = (m_rr == N - 1) ? 0 : m_rr + 1;
                end
                m_v[slot] = 1'b1; m_lp[slot] = ilp; m_fc[slot] = code_of(is); m_pp[slot] = ipp;
            end
        end
    endtask

    task automatic look(input logic [31:0] la, input logic s, input string req);
        op(1, la, s, 0, '0, '0, 0, 0, 0, '0, req);
    endtask

    task automatic put(input logic [23:0] lp, input logic [23:0] pp, input logic s);
        op(0, '0, 0, 1, lp, pp, s, 0, 0, '0, "");
    endtask

    task automatic ctl(input logic [15:8] c);
        op(0, '0, 0, 0, '0, '0, 0, 0, 1, c, "");
    endtask

    // monitor: compare mid-cycle, away from the active edge
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_cmp++;
            if (lk_hit !== e.hit || lk_paddr !== e.pa) begin
                n_bad++;
                $display("FAIL %s: hit=%0b pa=%08h expected hit=%0b pa=%08h",
                         e.req, lk_hit, lk_paddr, e.hit, e.pa);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        model_clear();
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;

        // R1: empty after reset
        look(32'h0000_1234, 0, "R1");
        look(32'hFFFF_FF00, 1, "R1");

        // R2 / R3: user and supervisor translations of one page
        put(24'h001234, 24'hABCDEF, 0);
        look(32'h0012_3456, 0, "R2");
        look(32'h0012_34FF, 0, "R2");
        look(32'h0012_3356, 0, "R2");
        look(32'h0012_3456, 1, "R3");
        put(24'h001234, 24'h777777, 1);
        look(32'h0012_3401, 1, "R3");
        look(32'h0012_3402, 0, "R3");

        // R4: duplicate insert keeps the original physical page
        put(24'h001234, 24'h555555, 0);
        look(32'h0012_3410, 0, "R4");

        // R9: same-cycle lookup and insert of one page
        op(1, 32'h00BE_EF20, 0, 1, 24'h00BEEF, 24'h0C0FFE, 0, 0, 0, '0, "R9");
        look(32'h00BE_EF21, 0, "R9");

        // R5 / R6: fill, overflow by 8, check, overflow by 15, check
        op(0, '0, 0, 0, '0, '0, 0, 1, 0, '0, "");
        for (int k = 0; k < 30; k++) put(24'h010000 + 24'(k), 24'h800000 + 24'(k), 0);
        for (int k = 0; k < 30; k++) look({24'h010000 + 24'(k), 8'h3C}, 0, "R5");
        for (int k = 30; k < 45; k++) put(24'h010000 + 24'(k), 24'h800000 + 24'(k), 0);
        for (int k = 0; k < 45; k++) look({24'h010000 + 24'(k), 8'h11}, 0, "R6");

        // R7: flush beats a simultaneous insert
        op(0, '0, 0, 1, 24'h0A0A0A, 24'h0B0B0B, 1, 1, 0, '0, "");
        look(32'h0A0A_0A00, 1, "R7");
        look({24'h010000 + 24'd40, 8'h00}, 0, "R7");

        // R8: command-word decode
        put(24'h00F00F, 24'h123456, 1);
        ctl(8'h41); look(32'h00F0_0F01, 1, "R8");
        ctl(8'h44); look(32'h00F0_0F02, 1, "R8");
        ctl(8'h42); look(32'h00F0_0F03, 1, "R8");
        ctl(8'h08); look(32'h00F0_0F04, 1, "R8");
        ctl(8'h40); look(32'h00F0_0F05, 1, "R8");
        put(24'h00F00F, 24'h123456, 1);
        ctl(8'h48); look(32'h00F0_0F06, 1, "R8");
        put(24'h00F00F, 24'h123456, 1);
        ctl(8'h4C); look(32'h00F0_0F07, 1, "R8");

        // R10: replacement restarts at entry 0 after a flush
        for (int k = 0; k < N + 1; k++) put(24'h200000 + 24'(k), 24'h300000 + 24'(k), 1);
        look(32'h2000_0000, 1, "R10");
        look(32'h2000_0100, 1, "R10");
        look({24'h200000 + 24'(N), 8'h44}, 1, "R10");

        @(posedge clk);
        @(posedge clk);
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule